// File: doc/BRIEF.md
# Flash Erase Status Flag Generator

This block models the status flags that a dual-bank flash device places on its data bus while an internal erase or program is running. It receives already-decoded commands (sector erase, program, erase suspend, erase resume and reset), a done pulse and a time-limit fault pulse from the internal operation engine, and a read strobe carrying the sector being read together with the chip-enable and output-enable levels. From these it keeps the operation mode, the set of sectors queued for erase and the erase acceptance window, and it drives five flag bits that a host polls to follow the operation.

The flags are a polling bit (low while work is pending), a general toggle bit that flips on each busy read, a sector toggle bit that flips only on reads of sectors in the erase set, a window-closed bit that tells software whether more sector erase commands can still be queued, and a sticky fault bit. The general and sector toggle bits differ during erase suspend, and reading both tells suspended-read apart from active erase. Array contents, the program algorithm and pin-level timing are not modelled.

Top module: `erase_status_gen`

## Requirements
- R1: After reset the block is in read mode: poll_o is 1 and tog_any_o, tog_sect_o, fault_o and win_closed_o are 0.
- R2: A sector erase command in read mode adds its sector to the erase set and opens the acceptance window; win_closed_o stays 0 for exactly WIN_CYC cycles after the last accepted erase command and then goes to 1. Each erase command inside the window adds its sector and restarts the window.
- R3: Once the window has closed, erase and program commands have no effect (the erase set and the flags are unchanged) until the engine's done pulse, which returns the block to read mode (poll_o 1, win_closed_o 0) and empties the erase set.
- R4: tog_any_o inverts on each read made during the window, the erase, a program, a program inside suspend or the fault state, and holds on reads in read mode and in suspended-read mode.
- R5: During the window, the erase and suspended-read, tog_sect_o inverts on a read of a sector in the erase set and holds on a read of any other sector.
- R6: During a program issued inside erase suspend, a read of a sector outside the erase set sets tog_sect_o to 1; a read of a sector inside the set inverts it.
- R7: The bank is the top BANK_W bits of the read sector. A read whose bank differs from the previous read's bank, with chip enable and output enable both held low in every cycle since that read, changes neither toggle bit; once either enable has been high in between, the toggles advance normally.
- R8: An engine fault pulse during an erase or program sets fault_o to 1 and poll_o to 0; fault_o stays 1, and every other command and engine pulse is ignored, until a reset command returns the block to read mode with an empty erase set.
- R9: A suspend command during the erase sets poll_o to 1 while win_closed_o stays 1; a program command in that mode sets poll_o to 0 until the done pulse returns to suspended-read, and a resume command goes back to the erase with poll_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_erase | input | 1 | Decoded sector erase command, one cycle |
| cmd_prog | input | 1 | Decoded program command, one cycle |
| cmd_suspend | input | 1 | Erase suspend request, one cycle |
| cmd_resume | input | 1 | Erase resume request, one cycle |
| cmd_reset | input | 1 | Reset command that leaves the fault state |
| cmd_sector | input | SECT_W | Sector of an erase command |
| eng_done | input | 1 | Completion pulse from the operation engine |
| eng_fault | input | 1 | Time-limit fault pulse from the operation engine |
| rd_stb | input | 1 | Status read strobe, one cycle per read |
| rd_sector | input | SECT_W | Sector addressed by the read |
| chip_en_n | input | 1 | Chip enable level, active low |
| out_en_n | input | 1 | Output enable level, active low |
| poll_o | output | 1 | Polling flag, 0 while work is pending |
| tog_any_o | output | 1 | General toggle flag |
| fault_o | output | 1 | Sticky time-limit fault flag |
| win_closed_o | output | 1 | 1 once the erase acceptance window has closed |
| tog_sect_o | output | 1 | Sector toggle flag |

## Verification
The assertions take for granted that the command decoder raises at most one of the five command strobes in a cycle, and one of them checks exactly that; the bench issues every command as a single-cycle pulse on its own. They also assume that the engine pulses arrive only in modes where the engine runs, which the stimulus respects, while the bench additionally sends erase, program and done pulses into modes that must ignore them. Reads are one-cycle strobes with both enables low in that cycle, and the bench chooses per read whether the enables go high afterwards, which is how the bank-change rule is reached.

// File: rtl/erase_status_pkg.sv
package erase_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WIN   = 3'd1,
    ST_ERASE = 3'd2,
    ST_SREAD = 3'd3,
    ST_SPROG = 3'd4,
    ST_PROG  = 3'd5,
    ST_FAULT = 3'd6
  } mode_e;

  // polling bit: high only when no work is pending
  function automatic logic poll_of(mode_e m);
    return (m == ST_IDLE) || (m == ST_SREAD);
  endfunction

  // erase has begun (window closed) and has not finished
  function automatic logic win_closed_of(mode_e m);
    return (m == ST_ERASE) || (m == ST_SREAD) || (m == ST_SPROG);
  endfunction

  // modes in which every read flips the general toggle
  function automatic logic any_tog_of(mode_e m);
    return (m == ST_WIN) || (m == ST_ERASE) || (m == ST_SPROG) ||
           (m == ST_PROG) || (m == ST_FAULT);
  endfunction

  // modes in which reads of queued sectors flip the sector toggle
  function automatic logic sect_tog_of(mode_e m);
    return (m == ST_WIN) || (m == ST_ERASE) || (m == ST_SREAD) ||
           (m == ST_SPROG);
  endfunction

endpackage

// File: rtl/ess_win_timer.sv
module ess_win_timer #(
  parameter int WIN_CYC = 64,
  localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(WIN_CYC - 1);
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ess_sector_set.sv
module ess_sector_set #(
  parameter int NUM_SECT = 16,
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_en,
  input  logic [SECT_W-1:0] add_idx,
  input  logic              clr,
  input  logic [SECT_W-1:0] rd_idx,
  output logic [NUM_SECT-1:0] set_o,
  output logic              hit_o
);

  logic [NUM_SECT-1:0] set_q;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        set_q[g] <= 1'b0;
      end else if (add_en && (add_idx == SECT_W'(g))) begin
        set_q[g] <= 1'b1;
      end
    end
  end

  assign set_o = set_q;
  assign hit_o = set_q[rd_idx];

endmodule

// File: rtl/ess_toggle.sv
module ess_toggle #(
  parameter int SECT_W = 4,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              any_en,
  input  logic              sect_en,
  input  logic              sect_force,
  input  logic              sect_hit,
  output logic              adv_o,
  output logic              tog_any_o,
  output logic              tog_sect_o
);

  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] last_bank_q;
  logic              released_q;
  logic              t_any_q;
  logic              t_sect_q;

  assign bank  = rd_sector[SECT_W-1 -: BANK_W];
  assign adv_o = released_q || (bank == last_bank_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_bank_q <= '0;
      released_q  <= 1'b1;
      t_any_q     <= 1'b0;
      t_sect_q    <= 1'b0;
    end else if (rd_stb) begin
      last_bank_q <= bank;
      released_q  <= 1'b0;
      if (adv_o) begin
        if (any_en) begin
          t_any_q <= ~t_any_q;
        end
        if (sect_en && sect_hit) begin
          t_sect_q <= ~t_sect_q;
        end else if (sect_force && !sect_hit) begin
          t_sect_q <= 1'b1;
        end
      end
    end else begin
      released_q <= released_q | chip_en_n | out_en_n;
    end
  end

  assign tog_any_o  = t_any_q;
  assign tog_sect_o = t_sect_q;

endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
  import erase_status_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int BANK_W   = 1,
  parameter int WIN_CYC  = 64,
  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_erase,
  input  logic              cmd_prog,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic              cmd_reset,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic              eng_done,
  input  logic              eng_fault,
  input  logic              rd_stb,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  output logic              poll_o,
  output logic              tog_any_o,
  output logic              fault_o,
  output logic              win_closed_o,
  output logic              tog_sect_o
);

  mode_e state_q, state_d;
  logic  set_add, set_clr, tmr_load, tmr_expired;
  logic  sect_hit, tog_adv;
  logic  [NUM_SECT-1:0] erase_set;
  logic  poll_q, fault_q, win_q;

  ess_win_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (tmr_load),
    .run       (state_q == ST_WIN),
    .expired_o (tmr_expired)
  );

  ess_sector_set #(.NUM_SECT(NUM_SECT)) u_set (
    .clk     (clk),
    .rst     (rst),
    .add_en  (set_add),
    .add_idx (cmd_sector),
    .clr     (set_clr),
    .rd_idx  (rd_sector),
    .set_o   (erase_set),
    .hit_o   (sect_hit)
  );

  ess_toggle #(.SECT_W(SECT_W), .BANK_W(BANK_W)) u_tog (
    .clk        (clk),
    .rst        (rst),
    .rd_stb     (rd_stb),
    .rd_sector  (rd_sector),
    .chip_en_n  (chip_en_n),
    .out_en_n   (out_en_n),
    .any_en     (any_tog_of(state_q)),
    .sect_en    (sect_tog_of(state_q)),
    .sect_force (state_q == ST_SPROG),
    .sect_hit   (sect_hit),
    .adv_o      (tog_adv),
    .tog_any_o  (tog_any_o),
    .tog_sect_o (tog_sect_o)
  );

  // mode sequencing: engine fault beats engine done beats commands
  always_comb begin
    state_d  = state_q;
    set_add  = 1'b0;
    set_clr  = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_erase) begin
          state_d  = ST_WIN;
          set_add  = 1'b1;
          tmr_load = 1'b1;
        end else if (cmd_prog) begin
          state_d = ST_PROG;
        end
      end
      ST_WIN: begin
        if (cmd_erase) begin
          set_add  = 1'b1;
          tmr_load = 1'b1;
        end else if (tmr_expired) begin
          state_d = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (eng_fault) begin
          state_d = ST_FAULT;
        end else if (eng_done) begin
          state_d = ST_IDLE;
          set_clr = 1'b1;
        end else if (cmd_suspend) begin
          state_d = ST_SREAD;
        end
      end
      ST_SREAD: begin
        if (cmd_resume) begin
          state_d = ST_ERASE;
        end else if (cmd_prog) begin
          state_d = ST_SPROG;
        end
      end
      ST_SPROG: begin
        if (eng_fault) begin
          state_d = ST_FAULT;
        end else if (eng_done) begin
          state_d = ST_SREAD;
        end
      end
      ST_PROG: begin
        if (eng_fault) begin
          state_d = ST_FAULT;
        end else if (eng_done) begin
          state_d = ST_IDLE;
        end
      end
      ST_FAULT: begin
        if (cmd_reset) begin
          state_d = ST_IDLE;
          set_clr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      poll_q  <= 1'b1;
      fault_q <= 1'b0;
      win_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_of(state_d);
      fault_q <= (state_d == ST_FAULT);
      win_q   <= win_closed_of(state_d);
    end
  end

  assign poll_o       = poll_q;
  assign fault_o      = fault_q;
  assign win_closed_o = win_q;

endmodule

// File: rtl/erase_status_chk.sv
module erase_status_chk
  import erase_status_pkg::*;
#(
  parameter int NUM_SECT = 16,
  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_erase,
  input logic                cmd_prog,
  input logic                cmd_suspend,
  input logic                cmd_resume,
  input logic                cmd_reset,
  input logic                rd_stb,
  input mode_e               state_q,
  input logic [NUM_SECT-1:0] erase_set,
  input logic                tog_adv,
  input logic                sect_hit,
  input logic                fault_o,
  input logic                win_closed_o,
  input logic                tog_any_o,
  input logic                tog_sect_o
);

  // input contract: one decoded command per cycle
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_erase, cmd_prog, cmd_suspend, cmd_resume, cmd_reset}));

  // R2
  win_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(win_closed_o) |-> $past(state_q == ST_WIN));

  // R3
  erase_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE && cmd_erase) |=> $stable(erase_set));

  // R4
  idle_tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && state_q == ST_IDLE) |=> $stable(tog_any_o));

  // R6
  sprog_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && state_q == ST_SPROG && !sect_hit && tog_adv) |=> tog_sect_o);

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !tog_adv) |=> ($stable(tog_any_o) && $stable(tog_sect_o)));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !cmd_reset) |=> fault_o);

endmodule

bind erase_status_gen erase_status_chk #(.NUM_SECT(NUM_SECT)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cmd_erase    (cmd_erase),
  .cmd_prog     (cmd_prog),
  .cmd_suspend  (cmd_suspend),
  .cmd_resume   (cmd_resume),
  .cmd_reset    (cmd_reset),
  .rd_stb       (rd_stb),
  .state_q      (state_q),
  .erase_set    (erase_set),
  .tog_adv      (tog_adv),
  .sect_hit     (sect_hit),
  .fault_o      (fault_o),
  .win_closed_o (win_closed_o),
  .tog_any_o    (tog_any_o),
  .tog_sect_o   (tog_sect_o)
);

// File: tb/erase_status_gen_tb_top.sv
module erase_status_gen_tb_top;

  localparam int NSECT = 16;
  localparam int BANKW = 1;
  localparam int WIN   = 12;
  localparam int SW    = 4;
  localparam int BANK_SPAN = NSECT >> BANKW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_erase = 0, cmd_prog = 0, cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0;
  logic [SW-1:0] cmd_sector = '0;
  logic eng_done = 0, eng_fault = 0;
  logic rd_stb = 0;
  logic [SW-1:0] rd_sector = '0;
  logic chip_en_n = 1, out_en_n = 1;
  logic poll_o, tog_any_o, fault_o, win_closed_o, tog_sect_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  erase_status_gen #(.NUM_SECT(NSECT), .BANK_W(BANKW), .WIN_CYC(WIN)) dut_i (
    .clk(clk), .rst(rst), .cmd_erase(cmd_erase), .cmd_prog(cmd_prog),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
    .cmd_sector(cmd_sector), .eng_done(eng_done), .eng_fault(eng_fault),
    .rd_stb(rd_stb), .rd_sector(rd_sector), .chip_en_n(chip_en_n),
    .out_en_n(out_en_n), .poll_o(poll_o), .tog_any_o(tog_any_o),
    .fault_o(fault_o), .win_closed_o(win_closed_o), .tog_sect_o(tog_sect_o)
  );

  // behavioural reference: 0 read,1 window,2 erase,3 susp-read,4 susp-prog,5 prog,6 fault
  int m_mode, m_cnt, m_lb, m_bk;
  logic [NSECT-1:0] m_set;
  logic m_t6, m_t2, m_rel, m_adv;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_set = '0; m_t6 = 0; m_t2 = 0; m_lb = 0; m_rel = 1;
    end else begin
      if (rd_stb) begin
        m_bk  = int'(rd_sector) / BANK_SPAN;
        m_adv = m_rel || (m_bk == m_lb);
        m_lb  = m_bk;
        m_rel = 0;
        if (m_adv) begin
          if (m_mode == 1 || m_mode == 2 || m_mode == 4 || m_mode == 5 || m_mode == 6)
            m_t6 = ~m_t6;
          if (m_mode >= 1 && m_mode <= 4) begin
            if (m_set[rd_sector]) m_t2 = ~m_t2;
            else if (m_mode == 4) m_t2 = 1;
          end
        end
      end else begin
        m_rel = m_rel | chip_en_n | out_en_n;
      end
      case (m_mode)
        0: if (cmd_erase) begin m_set[cmd_sector] = 1; m_cnt = WIN - 1; m_mode = 1; end
           else if (cmd_prog) m_mode = 5;
        1: if (cmd_erase) begin m_set[cmd_sector] = 1; m_cnt = WIN - 1; end
           else if (m_cnt == 0) m_mode = 2;
           else m_cnt = m_cnt - 1;
        2: if (eng_fault) m_mode = 6;
           else if (eng_done) begin m_mode = 0; m_set = '0; end
           else if (cmd_suspend) m_mode = 3;
        3: if (cmd_resume) m_mode = 2;
           else if (cmd_prog) m_mode = 4;
        4: if (eng_fault) m_mode = 6;
           else if (eng_done) m_mode = 3;
        5: if (eng_fault) m_mode = 6;
           else if (eng_done) m_mode = 0;
        6: if (cmd_reset) begin m_mode = 0; m_set = '0; end
        default: m_mode = 0;
      endcase
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison with the reference
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      logic [4:0] act, exp;
      act = {poll_o, tog_any_o, fault_o, win_closed_o, tog_sect_o};
      exp = {(m_mode == 0 || m_mode == 3), m_t6, (m_mode == 6),
             (m_mode >= 2 && m_mode <= 4), m_t2};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s reference compare actual %b expected %b", phase, act, exp);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_erase(int sec);
    cmd_erase = 1; cmd_sector = SW'(sec);
    @(negedge clk); cmd_erase = 0;
  endtask

  task automatic read(int sec, bit rel);
    chip_en_n = 0; out_en_n = 0; rd_stb = 1; rd_sector = SW'(sec);
    @(negedge clk);
    rd_stb = 0;
    if (rel) begin chip_en_n = 1; out_en_n = 1; end
    @(negedge clk);
  endtask

  initial begin
    logic t;
    int n;
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 poll", poll_o, 1'b1);
    chk("R1 flags", tog_any_o | tog_sect_o | fault_o | win_closed_o, 1'b0);

    phase = "R4";
    t = tog_any_o;
    read(5, 1);
    chk("R4 idle read hold", tog_any_o, t);

    phase = "R5";
    pulse_erase(3);
    t = tog_sect_o;
    read(3, 1);
    chk("R5 queued sector flips", tog_sect_o, ~t);
    t = tog_sect_o;
    read(5, 1);
    chk("R5 other sector holds", tog_sect_o, t);

    phase = "R2";
    pulse_erase(9);
    n = 0;
    while (!win_closed_o && n < 1000) begin n++; @(negedge clk); end
    checks++;
    if (n != WIN) begin
      errors++;
      $display("FAIL R2 window length actual %0d expected %0d", n, WIN);
    end
    chk("R2 poll low in erase", poll_o, 1'b0);

    phase = "R3";
    pulse_erase(1);
    t = tog_sect_o;
    read(1, 1);
    chk("R3 late erase ignored", tog_sect_o, t);
    cmd_prog = 1; @(negedge clk); cmd_prog = 0; @(negedge clk);
    chk("R3 program ignored", poll_o, 1'b0);
    read(9, 1);

    phase = "R9";
    cmd_suspend = 1; @(negedge clk); cmd_suspend = 0; @(negedge clk);
    chk("R9 suspend poll", poll_o, 1'b1);
    chk("R9 suspend window", win_closed_o, 1'b1);
    t = tog_any_o;
    read(3, 1);
    chk("R4 suspend-read any holds", tog_any_o, t);
    cmd_prog = 1; @(negedge clk); cmd_prog = 0; @(negedge clk);
    chk("R9 suspended program poll", poll_o, 1'b0);

    phase = "R6";
    read(3, 1);
    read(3, 1);
    if (tog_sect_o) read(3, 1);
    chk("R6 setup low", tog_sect_o, 1'b0);
    read(0, 1);
    chk("R6 outside set reads 1", tog_sect_o, 1'b1);

    phase = "R9";
    eng_done = 1; @(negedge clk); eng_done = 0; @(negedge clk);
    chk("R9 done back to suspend-read", poll_o, 1'b1);
    cmd_resume = 1; @(negedge clk); cmd_resume = 0; @(negedge clk);
    chk("R9 resume poll", poll_o, 1'b0);

    phase = "R3";
    eng_done = 1; @(negedge clk); eng_done = 0; @(negedge clk);
    chk("R3 done poll", poll_o, 1'b1);
    chk("R3 done window", win_closed_o, 1'b0);
    t = tog_sect_o;
    read(9, 1);
    chk("R3 set emptied", tog_sect_o, t);

    phase = "R7";
    cmd_prog = 1; @(negedge clk); cmd_prog = 0;
    read(2, 0);
    t = tog_any_o;
    read(12, 0);
    chk("R7 bank change held", tog_any_o, t);
    read(12, 1);
    chk("R7 same bank advances", tog_any_o, ~t);
    t = tog_any_o;
    read(2, 1);
    chk("R7 released bank change", tog_any_o, ~t);

    phase = "R8";
    eng_fault = 1; @(negedge clk); eng_fault = 0; @(negedge clk);
    chk("R8 fault set", fault_o, 1'b1);
    chk("R8 poll low", poll_o, 1'b0);
    eng_done = 1; @(negedge clk); eng_done = 0;
    pulse_erase(4);
    idle(3);
    chk("R8 fault sticky", fault_o, 1'b1);
    read(4, 1);
    cmd_reset = 1; @(negedge clk); cmd_reset = 0; @(negedge clk);
    chk("R8 reset clears", fault_o, 1'b0);
    chk("R8 read mode", poll_o, 1'b1);

    // second erase ending in fault during erase
    pulse_erase(6);
    idle(WIN + 2);
    eng_fault = 1; @(negedge clk); eng_fault = 0; @(negedge clk);
    chk("R8 erase fault", fault_o, 1'b1);
    cmd_reset = 1; @(negedge clk); cmd_reset = 0; @(negedge clk);
    pulse_erase(7);
    t = tog_sect_o;
    read(6, 1);
    chk("R8 set emptied by reset", tog_sect_o, t);
    idle(WIN + 2);
    eng_done = 1; @(negedge clk); eng_done = 0;
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule